// File: doc/BRIEF.md
# I2C Target Register Port

This block is a serial-bus target that lets an I2C controller reach a bank of four 8-bit registers held by a neighbouring block. It runs entirely from the system clock. It oversamples the SCL and SDA lines through two-flop synchronisers and finds clock edges and bus conditions on the synchronised copies. The open-drain data line is driven through a single pull-low enable. The register bank itself lives outside the block. The target presents a register index, a byte of write data with a one-cycle write strobe, and a one-cycle read strobe at the moment it captures `rd_data_i` for transmission.

Its 7-bit address is the fixed pattern 0100 followed by three strap inputs. After an address match with a write direction, the first byte sets a register pointer. Any further bytes are written to that register. After a match with a read direction, the target sends the pointed register, once per acknowledged byte. The pointer keeps its value from one transaction to the next, so a controller can set it once and then read the same register repeatedly. A repeated START allows it to be set and then read in one transaction.

The state machine has these states and transitions. IDLE moves to ADDR on START. ADDR moves to ADDR_ACK on a matching address byte, or back to IDLE on a mismatch. ADDR_ACK moves to CMD for a write or to RDATA for a read. CMD moves to CMD_ACK, which moves to WDATA. WDATA moves to WDATA_ACK, which returns to WDATA. RDATA moves to RACK. RACK returns to RDATA on a controller ACK, or goes to WAIT_STOP on a NACK. A STOP from any state leads to IDLE. A START from any state leads to ADDR.

Top module: `i2c_reg_target`

## Requirements
- R1: Before the first START, and after a STOP or an address mismatch, the target never pulls SDA low and gives no strobe, whatever the bus carries, until the next START.
- R2: The target responds only to an address byte whose upper seven bits equal 0100 followed by `strap_i[2:0]` (strap bit 2 first). The last bit selects the direction: 1 means read, 0 means write.
- R3: On a match, the target pulls SDA low during the ninth SCL clock of the address byte, including its high phase. It changes its SDA drive only while the synchronised SCL is low.
- R4: In a write, the target acknowledges the command byte and every later byte. Its bits [1:0] become `reg_idx_o`. Each later byte gives one single-cycle `wr_en_o` pulse, with the byte on `wr_data_o`, to that same index.
- R5: In a read, the target samples `rd_data_i` with a one-cycle `rd_en_o` pulse and sends it MSB first. After each controller ACK it sends another byte from the same index.
- R6: After a controller NACK, the target releases SDA, gives no further `rd_en_o` pulse and ignores SCL until STOP or START.
- R7: The pointer keeps its value across STOP and across later read transactions until a new command byte is received.
- R8: A repeated START after the command byte, followed by a read address, returns the register just selected without an intervening STOP.
- R9: A START or STOP in the middle of a byte abandons that byte: no `wr_en_o` pulse occurs for it and the pointer keeps its value.
- R10: After reset, `reg_idx_o` is 0, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 3 | Low three address bits, tied per instance |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| reg_idx_o | output | 2 | Current register pointer |
| wr_data_o | output | 8 | Byte to write into the pointed register |
| wr_en_o | output | 1 | One-cycle write strobe |
| rd_en_o | output | 1 | One-cycle strobe marking the capture of `rd_data_i` |
| rd_data_i | input | 8 | Contents of the pointed register |

## Verification
A wrong state is seen by the controller within the next nine SCL clocks. It appears as a missing or misplaced acknowledge, a bit read back at the wrong position, or a strobe in a byte where none belongs. Pointer errors cannot be seen while writing. They show up only when the register is read back in a later transaction, so every write in the bench is followed by a separate read transaction. Aborts and NACKs are checked through strobe counts and through the level of a released SDA line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         IDX_W       = 2,
    parameter int         STRAP_W     = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_BASE    = 7'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic [IDX_W-1:0]   reg_idx_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               wr_en_o,
    output logic               rd_en_o,
    input  logic [BYTE_W-1:0]  rd_data_i
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_tgt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_s),
        .sda      (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    tgt_state_e         st, st_nx;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               byte_full;
    logic               rw_q;
    logic               mack_q;
    logic [6:0]         own_addr;
    logic               addr_hit;

    assign own_addr = {DEV_BASE[6:STRAP_W], strap_i};
    assign addr_hit = (rx_sh[BYTE_W-1:1] == own_addr);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (stop_det) begin
            st_nx = ST_IDLE;
        end else if (start_det) begin
            st_nx = ST_ADDR;
        end else if (scl_fall) begin
            unique case (st)
                ST_IDLE, ST_WAIT_STOP: st_nx = st;
                ST_ADDR:      if (byte_full) st_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  st_nx = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_full) st_nx = ST_CMD_ACK;
                ST_CMD_ACK:   st_nx = ST_WDATA;
                ST_WDATA:     if (byte_full) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: st_nx = ST_WDATA;
                ST_RDATA:     if (byte_full) st_nx = ST_RACK;
                ST_RACK:      st_nx = mack_q ? ST_RDATA : ST_WAIT_STOP;
                default:      st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // bit counting and receive shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
        end else begin
            if (start_det || stop_det || (scl_fall && st_nx != st)) begin
                bit_cnt   <= '0;
                byte_full <= 1'b0;
            end else if (scl_rise) begin
                rx_sh     <= {rx_sh[BYTE_W-2:0], sda_s};
                bit_cnt   <= bit_cnt + 1'b1;
                byte_full <= (bit_cnt == LAST_BIT);
            end
            if (scl_fall && st == ST_ADDR && byte_full) rw_q <= rx_sh[0];
            if (scl_rise && st == ST_RACK) mack_q <= ~sda_s;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            tx_sh      <= '0;
            reg_idx_o  <= '0;
            wr_data_o  <= '0;
            wr_en_o    <= 1'b0;
            rd_en_o    <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            rd_en_o <= 1'b0;
            if (start_det || stop_det) begin
                sda_pull_o <= 1'b0;
            end else if (scl_fall) begin
                unique case (st)
                    ST_ADDR: begin
                        if (byte_full && addr_hit) sda_pull_o <= 1'b1;
                    end
                    ST_ADDR_ACK: begin
                        if (rw_q) begin
                            tx_sh      <= rd_data_i;
                            sda_pull_o <= ~rd_data_i[BYTE_W-1];
                            rd_en_o    <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (byte_full) begin
                            reg_idx_o  <= rx_sh[IDX_W-1:0];
                            sda_pull_o <= 1'b1;
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: sda_pull_o <= 1'b0;
                    ST_WDATA: begin
                        if (byte_full) begin
                            wr_data_o  <= rx_sh;
                            wr_en_o    <= 1'b1;
                            sda_pull_o <= 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (byte_full) begin
                            sda_pull_o <= 1'b0;
                        end else begin
                            tx_sh      <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (mack_q) begin
                            tx_sh      <= rd_data_i;
                            sda_pull_o <= ~rd_data_i[BYTE_W-1];
                            rd_en_o    <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: released while idle or waiting for STOP
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_WAIT_STOP) |-> !sda_pull_o);

    // R3: SDA drive changes only while synchronised SCL is low
    assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);

    // R4: a write strobe lasts one cycle
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R5: read and write strobes never coincide
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));

    // R7: pointer moves only when a command byte completes
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_idx_o) |-> $past(st) == ST_CMD);
endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_i;
    logic [2:0] strap_i = 3'b101;
    logic       sda_pull_o;
    logic [1:0] reg_idx_o;
    logic [7:0] wr_data_o;
    logic       wr_en_o;
    logic       rd_en_o;
    logic [7:0] rd_data_i;

    logic [7:0] bank [4];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_i = m_sda & ~sda_pull_o;
    assign rd_data_i = bank[reg_idx_o];

    i2c_reg_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .strap_i   (strap_i),
        .sda_pull_o(sda_pull_o),
        .reg_idx_o (reg_idx_o),
        .wr_data_o (wr_data_o),
        .wr_en_o   (wr_en_o),
        .rd_en_o   (rd_en_o),
        .rd_data_i (rd_data_i)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
        end else if (wr_en_o) begin
            bank[reg_idx_o] <= wr_data_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_en_o) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H);
        scl_i = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        scl_i = 1'b0;
    endtask

    task automatic bus_stop();
        wt(2); m_sda = 1'b0; wt(H);
        scl_i = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic bit_wr(input logic b);
        wt(2); m_sda = b; wt(H);
        scl_i = 1'b1; wt(H);
        scl_i = 1'b0;
    endtask

    task automatic bit_rd(output logic b);
        wt(2); m_sda = 1'b1; wt(H);
        scl_i = 1'b1; wt(H / 2);
        b = sda_i; wt(H / 2);
        scl_i = 1'b0;
    endtask

    task automatic byte_wr(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_wr(d[i]);
        bit_rd(b);
        acked = ~b;
    endtask

    task automatic byte_rd(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_rd(b);
            d[i] = b;
        end
        bit_wr(~give_ack);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
        return {4'b0100, s, rd};
    endfunction

    // {command byte, data byte}
    localparam logic [15:0] VEC [6] = '{
        16'h01A5, 16'h023C, 16'h03F0, 16'h005A, 16'h0781, 16'h0642
    };

    logic [7:0] exp_bank [4];

    initial begin
        logic ack;
        logic [7:0] d, d2;
        logic b;
        int w0, r0;
        for (int i = 0; i < 4; i++) exp_bank[i] = 8'h00;
        wt(5);
        chk("R10 pull in reset", int'(sda_pull_o), 0);
        rst_n = 1'b1;
        wt(5);
        chk("R10 idx", int'(reg_idx_o), 0);
        chk("R10 pull", int'(sda_pull_o), 0);
        chk("R10 strobes", int'({wr_en_o, rd_en_o}), 0);

        // R1: bus traffic before any START
        for (int i = 0; i < 4; i++) bit_wr(1'b0);
        chk("R1 no drive before START", int'(sda_pull_o), 0);
        bus_stop();

        // R10/R5: read at reset pointer
        bus_start();
        byte_wr(dev(3'b101, 1'b1), ack);
        chk("R2 read address ack", int'(ack), 1);
        byte_rd(d, 1'b0);
        chk("R5 default register read", int'(d), 0);
        bus_stop();

        // table: write via command, read back in new transaction
        foreach (VEC[k]) begin
            logic [7:0] cmd, dat;
            cmd = VEC[k][15:8];
            dat = VEC[k][7:0];
            w0 = wr_cnt;
            bus_start();
            byte_wr(dev(3'b101, 1'b0), ack);
            chk("R3 address ack", int'(ack), 1);
            byte_wr(cmd, ack);
            chk("R4 command ack", int'(ack), 1);
            byte_wr(dat, ack);
            chk("R4 data ack", int'(ack), 1);
            bus_stop();
            exp_bank[cmd[1:0]] = dat;
            chk("R4 one write strobe", wr_cnt - w0, 1);
            chk("R4 index from low bits", int'(reg_idx_o), int'(cmd[1:0]));
            bus_start();
            byte_wr(dev(3'b101, 1'b1), ack);
            byte_rd(d, 1'b0);
            bus_stop();
            chk("R7 readback via kept pointer", int'(d), int'(exp_bank[cmd[1:0]]));
        end

        // R4: two data bytes land in the same register
        w0 = wr_cnt;
        bus_start();
        byte_wr(dev(3'b101, 1'b0), ack);
        byte_wr(8'h01, ack);
        byte_wr(8'h11, ack);
        byte_wr(8'h22, ack);
        chk("R4 second data ack", int'(ack), 1);
        bus_stop();
        exp_bank[1] = 8'h22;
        chk("R4 two strobes", wr_cnt - w0, 2);
        chk("R4 same register", int'(bank[1]), 8'h22);
        chk("R4 neighbour untouched", int'(bank[0]), int'(exp_bank[0]));

        // R5/R6: ACK then NACK, then released line
        r0 = rd_cnt;
        bus_start();
        byte_wr(dev(3'b101, 1'b1), ack);
        byte_rd(d, 1'b1);
        byte_rd(d2, 1'b0);
        chk("R5 first byte", int'(d), 8'h22);
        chk("R5 second byte after ACK", int'(d2), 8'h22);
        bit_rd(b);
        chk("R6 released after NACK", int'(b), 1);
        bit_rd(b);
        bus_stop();
        chk("R6 no extra read strobe", rd_cnt - r0, 2);

        // R8: repeated START
        bus_start();
        byte_wr(dev(3'b101, 1'b0), ack);
        byte_wr(8'h03, ack);
        bus_start();
        byte_wr(dev(3'b101, 1'b1), ack);
        chk("R8 read after restart ack", int'(ack), 1);
        byte_rd(d, 1'b0);
        bus_stop();
        chk("R8 restart readback", int'(d), int'(exp_bank[3]));

        // R2/R1: mismatched addresses
        w0 = wr_cnt;
        bus_start();
        byte_wr(8'h5A, ack);
        chk("R2 wrong fixed bits nack", int'(ack), 0);
        byte_wr(8'h00, ack);
        chk("R1 silent after mismatch", int'(ack), 0);
        byte_wr(8'h99, ack);
        bus_stop();
        bus_start();
        byte_wr(dev(3'b100, 1'b0), ack);
        chk("R2 wrong strap nack", int'(ack), 0);
        byte_wr(8'h02, ack);
        byte_wr(8'h77, ack);
        bus_stop();
        chk("R1 no write on mismatch", wr_cnt - w0, 0);
        chk("R1 pointer kept on mismatch", int'(reg_idx_o), 3);
        strap_i = 3'b010;
        wt(5);
        bus_start();
        byte_wr(dev(3'b010, 1'b1), ack);
        chk("R2 new strap ack", int'(ack), 1);
        byte_rd(d, 1'b0);
        bus_stop();

        // R9: abort by STOP and by START mid-byte
        w0 = wr_cnt;
        bus_start();
        byte_wr(dev(3'b010, 1'b0), ack);
        byte_wr(8'h03, ack);
        for (int i = 0; i < 4; i++) bit_wr(1'b1);
        bus_stop();
        chk("R9 no write on STOP abort", wr_cnt - w0, 0);
        bus_start();
        byte_wr(dev(3'b010, 1'b0), ack);
        byte_wr(8'h00, ack);
        byte_wr(8'hC3, ack);
        for (int i = 0; i < 3; i++) bit_wr(1'b0);
        bus_start();
        byte_wr(dev(3'b010, 1'b1), ack);
        byte_rd(d, 1'b0);
        bus_stop();
        exp_bank[0] = 8'hC3;
        chk("R9 one write before START abort", wr_cnt - w0, 1);
        chk("R9 register keeps last full byte", int'(d), 8'hC3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule